// File: doc/BRIEF.md
# Overflow-Armed Event Sampling Unit

This block keeps four event counters and, for each one, lets a capture be armed by counter overflow. A counter that wraps from all-ones to zero while its capture enable is set does not capture at once. It only becomes armed. The next qualifying event on that counter triggers a capture. A qualifying event is a counter pulse that arrives together with a retiring instruction.

The capture is a record of 64-bit words. The first word is the address of the instruction that follows the triggering one. The remaining words are the architectural register values as they stand after the triggering instruction retires. Each counter keeps its own snapshot. Records leave the block on a ready/valid stream, tagged with the counter index, and the last word is flagged. Software programs the enables and preloads the counters through a simple write port. It reads them back through a registered read port.

Address 0 of the register port is the enable register. Addresses 1 to 4 are counters 0 to 3.

Top module: `ovf_sampler`

## Requirements
- R1: The enable register (address 0) resets to zero. It holds capture enables for counters 0..3 in bits 0..3 and latency enables for counters 0..3 in bits 32..35. Both groups read back as written, one cycle after rd_addr is presented.
- R2: Reserved bits of the enable register (bits 4..31 and 36..63) always read as zero; writing ones to them has no effect.
- R3: Counter i resets to zero and is written at address 1+i with the low CTR_W bits of wr_data. It reads back zero-extended. It increments by one on each cycle where evt_pulse[i] and ret_valid are both high. It wraps from all-ones to zero. A pulse without ret_valid does not count.
- R4: A wrap of a counter whose capture enable is set arms that counter but emits nothing. A wrap while the capture enable is clear does not arm it.
- R5: The first qualifying event on an armed counter triggers exactly one record. Further events before that record is fully emitted add nothing. Once the record is emitted the counter is disarmed and needs a new wrap before it can capture again.
- R6: A record is NUM_REGS+1 words. Word 0 is ret_ip + ret_len of the triggering instruction. Words 1..NUM_REGS are ret_regs slices 0..NUM_REGS-1 of that cycle, in ascending order. out_last is high on the final word only, and out_ctr carries the counter index.
- R7: When several counters have records pending, the lowest-numbered one is emitted first. The others wait and follow in ascending order.
- R8: Clearing a counter's capture enable drops its arming and any pending record that has not started emitting, so no record appears. A record whose first word is already on the stream is completed in full.
- R9: While out_valid is high and out_ready is low, out_valid, out_data, out_last and out_ctr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | ADDR_W (3) | Register read address |
| rd_data | output | 64 | Registered read data |
| evt_pulse | input | NUM_CTR (4) | Per-counter event pulses |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_ip | input | 64 | Address of the retiring instruction |
| ret_len | input | 4 | Length in bytes of the retiring instruction |
| ret_regs | input | NUM_REGS*64 (192) | Post-retirement register values, slice k at bits 64k+63..64k |
| out_valid | output | 1 | Record word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 64 | Record word |
| out_last | output | 1 | Final word of a record |
| out_ctr | output | CTR_IDX_W (2) | Counter that produced the record |

## Verification
On every cycle the assertions check several properties. A stalled stream word stays stable. A word on the stream belongs to a counter with a pending record. A pending record always sits on an armed counter. A disabled counter that is not being emitted loses its pending record on the next cycle. A new record never starts while a lower-numbered enabled counter is pending. Reserved enable bits read as zero.

Only the bench scenarios can show the rest: the contents and order of record words, and that a wrap alone emits nothing. They also show that a second event while a record is pending adds nothing, that re-triggering needs a fresh wrap, and that a drop under backpressure removes exactly the record that had not started.

// File: rtl/ovf_sampler_pkg.sv
`timescale 1ns/1ps
package ovf_sampler_pkg;
  localparam int WORD_W   = 64;
  localparam int LL_BASE  = 32;
  localparam int CTR_BASE = 1;
  localparam int LEN_W    = 4;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ovs_regs.sv
`timescale 1ns/1ps
module ovs_regs
  import ovf_sampler_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 16,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  word_t                    wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NUM_CTR*CTR_W-1:0] cnt_all,
  output logic [NUM_CTR-1:0]       cap_en_o,
  output logic [NUM_CTR-1:0]       cnt_wr_o,
  output logic [CTR_W-1:0]         cnt_wval_o,
  output word_t                    rd_data_o
);
  logic [NUM_CTR-1:0] cap_en_q, lat_en_q;
  word_t rd_q, rd_n;
  logic  unused_wr_bits;

  assign unused_wr_bits = ^wr_data;
  assign cnt_wval_o     = wr_data[CTR_W-1:0];
  assign cap_en_o       = cap_en_q;
  assign rd_data_o      = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en_q <= '0;
      lat_en_q <= '0;
    end else if (wr_en && wr_addr == '0) begin
      cap_en_q <= wr_data[NUM_CTR-1:0];
      lat_en_q <= wr_data[LL_BASE +: NUM_CTR];
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_wsel
    assign cnt_wr_o[i] = wr_en && (wr_addr == ADDR_W'(CTR_BASE + i));
  end

  always_comb begin
    rd_n = '0;
    if (rd_addr == '0) begin
      rd_n[NUM_CTR-1:0]         = cap_en_q;
      rd_n[LL_BASE +: NUM_CTR]  = lat_en_q;
    end
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_addr == ADDR_W'(CTR_BASE + i))
        rd_n = WORD_W'(cnt_all[i*CTR_W +: CTR_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end
endmodule

// File: rtl/ovs_counter.sv
`timescale 1ns/1ps
module ovs_counter
  import ovf_sampler_pkg::*;
#(
  parameter int CTR_W     = 16,
  parameter int NUM_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cap_en,
  input  logic                        wr_cnt,
  input  logic [CTR_W-1:0]            wr_val,
  input  logic                        evt,
  input  logic [NUM_WORDS*WORD_W-1:0] state_i,
  input  logic                        done,
  input  logic                        active,
  output logic [CTR_W-1:0]            count_o,
  output logic                        armed_o,
  output logic                        pending_o,
  output logic [NUM_WORDS*WORD_W-1:0] snap_o
);
  logic [CTR_W-1:0] count_q;
  logic armed_q, pending_q, wrap, trigger, drop;
  logic [NUM_WORDS*WORD_W-1:0] snap_q;

  assign wrap    = evt && !wr_cnt && (count_q == '1) && cap_en;
  assign trigger = evt && armed_q && !pending_q;
  assign drop    = !cap_en && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (wr_cnt) begin
      count_q <= wr_val;
    end else if (evt) begin
      count_q <= count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      pending_q <= 1'b0;
    end else if (drop || done) begin
      armed_q   <= wrap;
      pending_q <= 1'b0;
    end else begin
      if (wrap)    armed_q   <= 1'b1;
      if (trigger) pending_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (trigger) snap_q <= state_i;
  end

  assign count_o   = count_q;
  assign armed_o   = armed_q;
  assign pending_o = pending_q;
  assign snap_o    = snap_q;
endmodule

// File: rtl/ovs_emitter.sv
`timescale 1ns/1ps
module ovs_emitter
  import ovf_sampler_pkg::*;
#(
  parameter int NUM_CTR   = 4,
  parameter int NUM_WORDS = 4,
  parameter int CTR_IDX_W = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_CTR-1:0]                  cand_i,
  input  logic [NUM_CTR*NUM_WORDS*WORD_W-1:0] snap_all,
  input  logic                                out_ready,
  output logic                                out_valid,
  output word_t                               out_data,
  output logic                                out_last,
  output logic [CTR_IDX_W-1:0]                out_ctr,
  output logic [NUM_CTR-1:0]                  done_o,
  output logic [NUM_CTR-1:0]                  active_o
);
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NUM_WORDS - 1);

  logic                 busy_q, last_q, found;
  logic [CTR_IDX_W-1:0] sel_q, pick;
  logic [WIDX_W-1:0]    widx_q, widx_nx;
  word_t                data_q;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NUM_CTR - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        pick  = CTR_IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign widx_nx = widx_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      sel_q  <= '0;
      widx_q <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (found) begin
        busy_q <= 1'b1;
        sel_q  <= pick;
        widx_q <= '0;
        data_q <= snap_all[(int'(pick) * NUM_WORDS) * WORD_W +: WORD_W];
        last_q <= (NUM_WORDS == 1);
      end
    end else if (out_ready) begin
      if (last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        widx_q <= widx_nx;
        data_q <= snap_all[(int'(sel_q) * NUM_WORDS + int'(widx_nx)) * WORD_W +: WORD_W];
        last_q <= (widx_nx == LAST_W);
      end
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_flags
    assign active_o[i] = busy_q && (sel_q == CTR_IDX_W'(i));
    assign done_o[i]   = active_o[i] && out_ready && last_q;
  end

  assign out_valid = busy_q;
  assign out_data  = data_q;
  assign out_last  = last_q;
  assign out_ctr   = sel_q;
endmodule

// File: rtl/ovf_sampler.sv
`timescale 1ns/1ps
module ovf_sampler
  import ovf_sampler_pkg::*;
#(
  parameter  int NUM_CTR   = 4,
  parameter  int CTR_W     = 16,
  parameter  int NUM_REGS  = 3,
  localparam int CTR_IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
  localparam int ADDR_W    = $clog2(NUM_CTR + CTR_BASE)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  input  logic [NUM_CTR-1:0]         evt_pulse,
  input  logic                       ret_valid,
  input  logic [WORD_W-1:0]          ret_ip,
  input  logic [LEN_W-1:0]           ret_len,
  input  logic [NUM_REGS*WORD_W-1:0] ret_regs,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WORD_W-1:0]          out_data,
  output logic                       out_last,
  output logic [CTR_IDX_W-1:0]       out_ctr
);
  localparam int NUM_WORDS = NUM_REGS + 1;

  logic [NUM_CTR-1:0] cap_en_w, cnt_wr_w, pending_w, armed_w, done_w, active_w;
  logic [CTR_W-1:0]   cnt_wval_w;
  logic [NUM_CTR*CTR_W-1:0] cnt_all_w;
  logic [NUM_CTR*NUM_WORDS*WORD_W-1:0] snap_all_w;
  logic [NUM_WORDS*WORD_W-1:0] state_w;

  assign state_w = {ret_regs, ret_ip + WORD_W'(ret_len)};

  ovs_regs #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt_all(cnt_all_w), .cap_en_o(cap_en_w),
    .cnt_wr_o(cnt_wr_w), .cnt_wval_o(cnt_wval_w), .rd_data_o(rd_data)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    ovs_counter #(.CTR_W(CTR_W), .NUM_WORDS(NUM_WORDS)) ctr_i (
      .clk(clk), .rst(rst), .cap_en(cap_en_w[i]), .wr_cnt(cnt_wr_w[i]),
      .wr_val(cnt_wval_w), .evt(evt_pulse[i] && ret_valid), .state_i(state_w),
      .done(done_w[i]), .active(active_w[i]),
      .count_o(cnt_all_w[i*CTR_W +: CTR_W]), .armed_o(armed_w[i]),
      .pending_o(pending_w[i]),
      .snap_o(snap_all_w[i*NUM_WORDS*WORD_W +: NUM_WORDS*WORD_W])
    );
  end

  ovs_emitter #(.NUM_CTR(NUM_CTR), .NUM_WORDS(NUM_WORDS), .CTR_IDX_W(CTR_IDX_W)) emit_i (
    .clk(clk), .rst(rst), .cand_i(pending_w & cap_en_w), .snap_all(snap_all_w),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ctr(out_ctr), .done_o(done_w), .active_o(active_w)
  );
endmodule

// File: rtl/ovs_checker.sv
`timescale 1ns/1ps
module ovs_checker
  import ovf_sampler_pkg::*;
#(
  parameter int NUM_CTR   = 4,
  parameter int CTR_IDX_W = 2,
  parameter int ADDR_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [WORD_W-1:0]    out_data,
  input logic                 out_last,
  input logic [CTR_IDX_W-1:0] out_ctr,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic [WORD_W-1:0]    rd_data,
  input logic [NUM_CTR-1:0]   pending,
  input logic [NUM_CTR-1:0]   armed,
  input logic [NUM_CTR-1:0]   cap_en,
  input logic [NUM_CTR-1:0]   active
);
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_ctr));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_addr) == '0 |-> rd_data[LL_BASE-1:NUM_CTR] == '0 && rd_data[WORD_W-1:LL_BASE+NUM_CTR] == '0);

  a_r6_word_owner: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pending[out_ctr]);

  a_r5_pending_armed: assert property (@(posedge clk) disable iff (rst)
    (pending & ~armed) == '0);

  a_r7_lowest_first: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> ($past(pending & cap_en) & ((NUM_CTR'(1) << out_ctr) - NUM_CTR'(1))) == '0);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_drop
    a_r8_drop_pending: assert property (@(posedge clk) disable iff (rst)
      pending[i] && !cap_en[i] && !active[i] |=> !pending[i]);
  end
endmodule

bind ovf_sampler ovs_checker #(.NUM_CTR(NUM_CTR), .CTR_IDX_W(CTR_IDX_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .out_ctr(out_ctr),
  .rd_addr(rd_addr), .rd_data(rd_data), .pending(pending_w),
  .armed(armed_w), .cap_en(cap_en_w), .active(active_w)
);

// File: tb/ovf_sampler_tb_top.sv
`timescale 1ns/1ps
module ovf_sampler_tb_top;
  localparam int NR = 3;
  localparam int NW = NR + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [63:0] wr_data = '0, rd_data, ret_ip = '0, out_data;
  logic [3:0] evt_pulse = '0, ret_len = '0;
  logic ret_valid = 1'b0, out_valid, out_ready, out_last;
  logic [NR*64-1:0] ret_regs = '0;
  logic [1:0] out_ctr;

  always #5 clk = ~clk;

  ovf_sampler dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt_pulse),
    .ret_valid(ret_valid), .ret_ip(ret_ip), .ret_len(ret_len), .ret_regs(ret_regs),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_ctr(out_ctr)
  );

  typedef struct { logic [63:0] d; logic l; logic [1:0] c; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int rmode = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (rmode)
        0: out_ready = 1'b1;
        1: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          out_ready = lfsr[0];
        end
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor: scoreboard compare and stall stability (R9)
  bit stall_prev = 1'b0;
  logic [63:0] pd;
  logic [1:0] pc;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev)
        chk(out_valid && out_data == pd && out_ctr == pc, "R9 stall hold", out_data, pd);
      stall_prev = out_valid && !out_ready;
      pd = out_data;
      pc = out_ctr;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5 unexpected record word", out_data, 64'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_data == e.d, {e.tag, " data"}, out_data, e.d);
          chk(out_last == e.l, {e.tag, " last (R6)"}, 64'(out_last), 64'(e.l));
          chk(out_ctr == e.c, {e.tag, " ctr (R7)"}, 64'(out_ctr), 64'(e.c));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    summary();
  end

  function automatic logic [NR*64-1:0] mkregs(input logic [63:0] s);
    mkregs = {s ^ 64'hC3C3_0000_FFFF_0003, s ^ 64'h0F0F_1111_2222_0002, s ^ 64'hA5A5_5A5A_0000_0001};
  endfunction

  task automatic push_rec(input logic [1:0] c, input logic [63:0] ip, input logic [3:0] len,
                          input logic [NR*64-1:0] regs, input string tag);
    q.push_back('{ip + 64'(len), 1'b0, c, tag});
    for (int k = 0; k < NR; k++)
      q.push_back('{regs[k*64 +: 64], (k == NR - 1), c, tag});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    rd_addr = a;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic ev(input logic [3:0] m, input bit rv, input logic [63:0] ip,
                    input logic [3:0] len, input logic [NR*64-1:0] regs);
    evt_pulse = m; ret_valid = rv; ret_ip = ip; ret_len = len; ret_regs = regs;
    @(posedge clk); #1;
    evt_pulse = '0; ret_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (q.size() != 0 && t < 500) begin
      @(posedge clk);
      t++;
    end
    idle(8);
    chk(q.size() == 0, tag, 64'(q.size()), 64'h0);
  endtask

  logic [63:0] v;
  logic [NR*64-1:0] rg;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // reset state
    chk(out_valid == 1'b0, "R5 no word after reset", 64'(out_valid), 64'h0);
    rd(3'd0, v); chk(v == 64'h0, "R1 enable reset", v, 64'h0);
    rd(3'd1, v); chk(v == 64'h0, "R3 counter reset", v, 64'h0);

    // enable register layout and reserved bits
    wr(3'd0, '1);
    rd(3'd0, v); chk(v == 64'h0000000F_0000000F, "R2 reserved read zero", v, 64'h0000000F_0000000F);
    wr(3'd0, 64'h00000005_0000000A);
    rd(3'd0, v); chk(v == 64'h00000005_0000000A, "R1 enable fields", v, 64'h00000005_0000000A);
    wr(3'd0, 64'h0);

    // counter write, count, ignore pulses without retirement
    wr(3'd3, 64'hABCD_0000_0000_1234);
    rd(3'd3, v); chk(v == 64'h1234, "R3 counter write", v, 64'h1234);
    for (int k = 0; k < 3; k++) ev(4'b0100, 1'b1, 64'h100, 4'd2, '0);
    ev(4'b0100, 1'b0, 64'h100, 4'd2, '0);
    rd(3'd3, v); chk(v == 64'h1237, "R3 qualified counting", v, 64'h1237);

    // wrap with capture disabled: no arming
    wr(3'd2, 64'hFFFF);
    ev(4'b0010, 1'b1, 64'h200, 4'd3, '0);
    rd(3'd2, v); chk(v == 64'h0, "R3 wrap to zero", v, 64'h0);
    wr(3'd0, 64'h2);
    ev(4'b0010, 1'b1, 64'h204, 4'd3, mkregs(64'h11));
    idle(8); chk(out_valid == 1'b0, "R4 disabled wrap not armed", 64'(out_valid), 64'h0);

    // arm then trigger on counter 0
    wr(3'd0, 64'h1);
    wr(3'd1, 64'hFFFF);
    ev(4'b0001, 1'b1, 64'h1000, 4'd4, mkregs(64'h22));
    idle(6); chk(out_valid == 1'b0, "R4 wrap emits nothing", 64'(out_valid), 64'h0);
    rg = mkregs(64'h3333_4444);
    push_rec(2'd0, 64'h0000_7FFF_0000_2000, 4'd7, rg, "R6 record words");
    ev(4'b0001, 1'b1, 64'h0000_7FFF_0000_2000, 4'd7, rg);
    ev(4'b0001, 1'b1, 64'h3000, 4'd1, mkregs(64'h44));
    drain("R5 single record");
    ev(4'b0001, 1'b1, 64'h4000, 4'd1, mkregs(64'h55));
    idle(10); chk(out_valid == 1'b0, "R5 rearm needs new wrap", 64'(out_valid), 64'h0);

    // simultaneous triggers with backpressure
    rmode = 1;
    wr(3'd0, 64'hB);
    wr(3'd1, 64'hFFFF); wr(3'd2, 64'hFFFF); wr(3'd4, 64'hFFFF);
    ev(4'b1011, 1'b1, 64'h5000, 4'd2, '0);
    rg = mkregs(64'h6666);
    push_rec(2'd0, 64'h6000, 4'd5, rg, "R7 order c0");
    push_rec(2'd1, 64'h6000, 4'd5, rg, "R7 order c1");
    push_rec(2'd3, 64'h6000, 4'd5, rg, "R7 order c3");
    ev(4'b1011, 1'b1, 64'h6000, 4'd5, rg);
    drain("R7 all records");
    rmode = 0;

    // drop of a pending record that has not started
    rmode = 2; idle(3);
    wr(3'd0, 64'h3);
    wr(3'd1, 64'hFFFF); wr(3'd2, 64'hFFFF);
    ev(4'b0011, 1'b1, 64'h7000, 4'd2, '0);
    rg = mkregs(64'h7777);
    push_rec(2'd0, 64'h7100, 4'd3, rg, "R8 kept record");
    ev(4'b0011, 1'b1, 64'h7100, 4'd3, rg);
    idle(4);
    chk(out_valid && out_ctr == 2'd0, "R7 lowest started", 64'(out_ctr), 64'h0);
    wr(3'd0, 64'h1);
    idle(2);
    rmode = 0;
    drain("R8 dropped record absent");
    wr(3'd0, 64'h3);
    ev(4'b0010, 1'b1, 64'h7200, 4'd1, mkregs(64'h88));
    idle(10); chk(out_valid == 1'b0, "R8 dropped counter disarmed", 64'(out_valid), 64'h0);

    // disable while armed, before any trigger
    wr(3'd0, 64'h4);
    wr(3'd3, 64'hFFFF);
    ev(4'b0100, 1'b1, 64'h8000, 4'd1, '0);
    wr(3'd0, 64'h0);
    wr(3'd0, 64'h4);
    ev(4'b0100, 1'b1, 64'h8100, 4'd1, mkregs(64'h99));
    idle(10); chk(out_valid == 1'b0, "R8 armed counter dropped", 64'(out_valid), 64'h0);

    // disable while a record is already being emitted: completes
    rmode = 2; idle(3);
    wr(3'd0, 64'h8);
    wr(3'd4, 64'hFFFF);
    ev(4'b1000, 1'b1, 64'h9000, 4'd1, '0);
    rg = mkregs(64'hAAAA_BBBB);
    push_rec(2'd3, 64'h9100, 4'd15, rg, "R8 started record completes");
    ev(4'b1000, 1'b1, 64'h9100, 4'd15, rg);
    idle(4);
    chk(out_valid && out_ctr == 2'd3, "R8 record started", 64'(out_ctr), 64'h3);
    wr(3'd0, 64'h0);
    idle(2);
    rmode = 1;
    drain("R8 full record");
    rmode = 0;

    summary();
  end
endmodule